// File: doc/BRIEF.md
# I2C Bus Status Flag Tracker

This block keeps the status flags of a two-wire serial bus controller. It watches the raw clock (SCL) and data (SDA) lines through synchronizers, finds Start, Stop and repeated Start conditions on them, and combines those with event strobes from the controller. The strobes are: start generated, address phase done (with the address byte), arbitration lost, and byte transfer in progress. From these it keeps six flags: bus busy, master role, transmit direction, general call seen, arbitration lost and bus error.

Software reads two 8-bit words through a small register port. The status word holds the role, busy, direction and general-call flags. The error word holds the arbitration-lost and bus-error flags, and software clears them by writing zeros. Address matching, data shifting and clock generation are done by the controller. Only their strobes and the address byte reach this block.

Top module: `i2c_status_tracker`

## Requirements
- R1: After reset every flag is 0. The status word (reg_addr=0) carries master role at bit 0, busy at bit 1, transmit direction at bit 2 and general call at bit 4. Bits 3 and 5 to 7 read 0. The error word (reg_addr=1) carries bus error at bit 0 and arbitration lost at bit 1. Bits 2 to 7 read 0.
- R2: Busy goes to 1 when the synchronized SCL or SDA is low. It goes to 0 only when a Stop (SDA rising while SCL stays high) is seen. It keeps tracking the bus while periph_en is 0.
- R3: Master role goes to 1 on a start_gen strobe while periph_en is 1. It goes to 0 on a Stop, on arb_lost, or while periph_en is 0. These clears win over the set.
- R4: On an addr_done strobe with periph_en at 1, transmit direction takes addr_byte bit 0 (1 = transmit). It goes to 0 on a Stop, on a repeated Start (a Start, SDA falling while SCL stays high, seen while busy is already 1), on arb_lost, or while periph_en is 0. These clears win.
- R5: General call goes to 1 on an addr_done strobe when addr_byte is 0x00, gc_en is 1 and periph_en is 1. It goes to 0 on a Stop, on a repeated Start, or while periph_en is 0.
- R6: An arb_lost strobe with periph_en at 1 sets arbitration lost. On the same edge it forces master role to 0.
- R7: A Start or Stop seen while xfer_active is 1 and periph_en is 1 sets bus error.
- R8: A write to the error word clears each error flag whose written bit is 0 and keeps each flag whose written bit is 1. A hardware set on the same edge wins over the clear. Writes to the status word change nothing.
- R9: While periph_en is 0, master role, direction, general call and both error flags are held at 0.
- R10: A level change on SCL or SDA acts on the flags at the third rising clock edge after it is applied, after two synchronizer stages and one edge-detect stage.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_in | input | 1 | Raw SCL line level |
| sda_in | input | 1 | Raw SDA line level |
| periph_en | input | 1 | Peripheral enable |
| gc_en | input | 1 | General-call recognition enable |
| start_gen | input | 1 | Strobe: controller generated a Start as master |
| addr_done | input | 1 | Strobe: address phase complete |
| addr_byte | input | 8 | Address byte, bit 0 is the R/W bit |
| arb_lost | input | 1 | Strobe: controller lost arbitration |
| xfer_active | input | 1 | Level: a byte transfer is in progress |
| reg_addr | input | 1 | Register select: 0 status word, 1 error word |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Read data of the selected word |

## Verification
The assertions assume that the controller strobes last one clock cycle and that addr_byte is valid in the cycle addr_done is high. They also assume the bus lines change slowly compared with the clock. The direction check further assumes that no Stop, repeated Start or arbitration loss lands in the same cycle as an address strobe. The stimulus drives every input once per cycle at the falling edge, so each strobe is a single-cycle pulse, and it holds the lines for several cycles between toggles. Cycles where a clear and a load collide are left to the bench model, which applies the clear-wins priority itself.

// File: rtl/i2cst_pkg.sv
// Shared constants and types for the bus status tracker.
// Assumes the two bus lines are packed SCL at index 0 and SDA at index 1.
package i2cst_pkg;
    localparam int N_LINES  = 2;
    localparam int LINE_SCL = 0;
    localparam int LINE_SDA = 1;
    localparam int WORD_W   = 8;
    localparam int ST_MSL   = 0;
    localparam int ST_BUSY  = 1;
    localparam int ST_TRA   = 2;
    localparam int ST_GC    = 4;
    localparam int ER_BERR  = 0;
    localparam int ER_ARLO  = 1;

    typedef struct packed {
        logic start;
        logic stop;
        logic line_low;
    } bus_evt_t;
endpackage

// File: rtl/i2cst_line_sync.sv
// Multi-stage synchronizer for a group of asynchronous lines, plus a
// one-cycle history register for edge detection.
// Assumes the lines idle high, so every stage resets to 1.
module i2cst_line_sync #(
    parameter int WIDTH  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] raw,
    output logic [WIDTH-1:0] cur,
    output logic [WIDTH-1:0] prev
);
    logic [WIDTH-1:0] chain [STAGES];

    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                // capture the raw lines
                always_ff @(posedge clk) begin
                    if (!rst_n) chain[0] <= '1;
                    else        chain[0] <= raw;
                end
            end else begin : g_next
                // pass the value one stage further
                always_ff @(posedge clk) begin
                    if (!rst_n) chain[g] <= '1;
                    else        chain[g] <= chain[g-1];
                end
            end
        end
    endgenerate

    // hold the previous synchronized value for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) prev <= '1;
        else        prev <= chain[STAGES-1];
    end

    assign cur = chain[STAGES-1];
endmodule

// File: rtl/i2cst_cond_detect.sv
// Finds Start and Stop conditions and a low level on either line from
// the synchronized current and previous line values.
// Assumes SCL and SDA never change together in one sampled step.
module i2cst_cond_detect
    import i2cst_pkg::*;
(
    input  logic [N_LINES-1:0] cur,
    input  logic [N_LINES-1:0] prev,
    output bus_evt_t           evt
);
    logic scl_high_both;

    // decode bus conditions from the line history
    always_comb begin
        scl_high_both = cur[LINE_SCL] & prev[LINE_SCL];
        evt.start     = scl_high_both & prev[LINE_SDA] & ~cur[LINE_SDA];
        evt.stop      = scl_high_both & ~prev[LINE_SDA] & cur[LINE_SDA];
        evt.line_low  = ~cur[LINE_SCL] | ~cur[LINE_SDA];
    end
endmodule

// File: rtl/i2cst_flag_core.sv
// Holds the six status flags and applies their set and clear rules.
// Assumes controller strobes are single-cycle pulses; clears have priority
// over sets except for error flags, where a hardware set beats a software clear.
module i2cst_flag_core
    import i2cst_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  bus_evt_t          evt,
    input  logic              periph_en,
    input  logic              gc_en,
    input  logic              start_gen,
    input  logic              addr_done,
    input  logic [ADDR_W-1:0] addr_byte,
    input  logic              arb_lost,
    input  logic              xfer_active,
    input  logic              clr_arlo,
    input  logic              clr_berr,
    output logic              msl,
    output logic              busy,
    output logic              tra,
    output logic              gcall,
    output logic              arlo,
    output logic              berr,
    output logic              rstart
);
    logic clr_common;
    logic gc_hdr;
    logic hw_arlo;
    logic hw_berr;

    // derive shared clear and set terms
    always_comb begin
        rstart     = evt.start & busy;
        clr_common = evt.stop | rstart | ~periph_en;
        gc_hdr     = addr_done & periph_en & gc_en & (addr_byte == '0);
        hw_arlo    = arb_lost & periph_en;
        hw_berr    = (evt.start | evt.stop) & xfer_active & periph_en;
    end

    // bus busy follows the lines regardless of enable
    always_ff @(posedge clk) begin
        if (!rst_n)            busy <= 1'b0;
        else if (evt.stop)     busy <= 1'b0;
        else if (evt.line_low) busy <= 1'b1;
    end

    // master role
    always_ff @(posedge clk) begin
        if (!rst_n)                                busy_guard_msl: msl <= 1'b0;
        else if (evt.stop | arb_lost | ~periph_en) msl <= 1'b0;
        else if (start_gen)                        msl <= 1'b1;
    end

    // transfer direction
    always_ff @(posedge clk) begin
        if (!rst_n)                      tra <= 1'b0;
        else if (clr_common | arb_lost)  tra <= 1'b0;
        else if (addr_done)              tra <= addr_byte[0];
    end

    // general call header seen
    always_ff @(posedge clk) begin
        if (!rst_n)          gcall <= 1'b0;
        else if (clr_common) gcall <= 1'b0;
        else if (gc_hdr)     gcall <= 1'b1;
    end

    // arbitration lost error flag
    always_ff @(posedge clk) begin
        if (!rst_n)          arlo <= 1'b0;
        else if (!periph_en) arlo <= 1'b0;
        else if (hw_arlo)    arlo <= 1'b1;
        else if (clr_arlo)   arlo <= 1'b0;
    end

    // misplaced start/stop error flag
    always_ff @(posedge clk) begin
        if (!rst_n)          berr <= 1'b0;
        else if (!periph_en) berr <= 1'b0;
        else if (hw_berr)    berr <= 1'b1;
        else if (clr_berr)   berr <= 1'b0;
    end
endmodule

// File: rtl/i2cst_reg_port.sv
// Software view: assembles the two words, muxes the read data and turns
// writes to the error word into per-flag clear strobes.
// Assumes a single select bit: 0 status word, 1 error word.
module i2cst_reg_port
    import i2cst_pkg::*;
(
    input  logic              reg_addr,
    input  logic              reg_wr,
    input  logic [WORD_W-1:0] reg_wdata,
    input  logic              msl,
    input  logic              busy,
    input  logic              tra,
    input  logic              gcall,
    input  logic              arlo,
    input  logic              berr,
    output logic [WORD_W-1:0] stat_word,
    output logic [WORD_W-1:0] err_word,
    output logic [WORD_W-1:0] rdata,
    output logic              clr_arlo,
    output logic              clr_berr
);
    // pack flags into their bit positions
    always_comb begin
        stat_word         = '0;
        stat_word[ST_MSL] = msl;
        stat_word[ST_BUSY]= busy;
        stat_word[ST_TRA] = tra;
        stat_word[ST_GC]  = gcall;
        err_word          = '0;
        err_word[ER_BERR] = berr;
        err_word[ER_ARLO] = arlo;
    end

    // select read data and decode write-zero clears
    always_comb begin
        rdata    = reg_addr ? err_word : stat_word;
        clr_arlo = reg_wr & reg_addr & ~reg_wdata[ER_ARLO];
        clr_berr = reg_wr & reg_addr & ~reg_wdata[ER_BERR];
    end
endmodule

// File: rtl/i2c_status_tracker.sv
// Top level: synchronizes the bus lines, detects bus conditions, keeps
// the status flags and serves the register port.
// Assumes clk is much faster than the bus clock.
module i2c_status_tracker
    import i2cst_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int ADDR_W      = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_in,
    input  logic              sda_in,
    input  logic              periph_en,
    input  logic              gc_en,
    input  logic              start_gen,
    input  logic              addr_done,
    input  logic [ADDR_W-1:0] addr_byte,
    input  logic              arb_lost,
    input  logic              xfer_active,
    input  logic              reg_addr,
    input  logic              reg_wr,
    input  logic [WORD_W-1:0] reg_wdata,
    output logic [WORD_W-1:0] reg_rdata
);
    logic [N_LINES-1:0] raw_lines;
    logic [N_LINES-1:0] cur_lines;
    logic [N_LINES-1:0] prev_lines;
    bus_evt_t           bus_evt;
    logic               msl, busy, tra, gcall, arlo, berr, rstart;
    logic               clr_arlo, clr_berr;
    logic [WORD_W-1:0]  stat_word, err_word;

    assign raw_lines[LINE_SCL] = scl_in;
    assign raw_lines[LINE_SDA] = sda_in;

    i2cst_line_sync #(.WIDTH(N_LINES), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .raw(raw_lines),
        .cur(cur_lines), .prev(prev_lines)
    );

    i2cst_cond_detect u_cond (
        .cur(cur_lines), .prev(prev_lines), .evt(bus_evt)
    );

    i2cst_flag_core #(.ADDR_W(ADDR_W)) u_flags (
        .clk(clk), .rst_n(rst_n), .evt(bus_evt),
        .periph_en(periph_en), .gc_en(gc_en), .start_gen(start_gen),
        .addr_done(addr_done), .addr_byte(addr_byte), .arb_lost(arb_lost),
        .xfer_active(xfer_active), .clr_arlo(clr_arlo), .clr_berr(clr_berr),
        .msl(msl), .busy(busy), .tra(tra), .gcall(gcall),
        .arlo(arlo), .berr(berr), .rstart(rstart)
    );

    i2cst_reg_port u_regs (
        .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
        .msl(msl), .busy(busy), .tra(tra), .gcall(gcall),
        .arlo(arlo), .berr(berr),
        .stat_word(stat_word), .err_word(err_word), .rdata(reg_rdata),
        .clr_arlo(clr_arlo), .clr_berr(clr_berr)
    );
endmodule

// File: rtl/i2cst_checker.sv
// Property checker for the status tracker, bound to the top module.
// Assumes single-cycle controller strobes.
module i2cst_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       periph_en,
    input logic       arb_lost,
    input logic       addr_done,
    input logic       rw_bit,
    input logic [7:0] stat,
    input logic [7:0] err,
    input logic       stop_det,
    input logic       rstart_det
);
    // R2
    stop_clears_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> !stat[1]);

    // R6
    arlo_drops_master_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (arb_lost && periph_en) |=> (!stat[0] && err[1]));

    // R9
    disable_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !periph_en |=> (!stat[0] && !stat[2] && !stat[4] && err[1:0] == 2'b00));

    // R4
    dir_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_done && periph_en && !stop_det && !rstart_det && !arb_lost)
        |=> (stat[2] == $past(rw_bit)));

    // R5
    rstart_clears_gc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rstart_det |=> (!stat[4] && !stat[2]));
endmodule

bind i2c_status_tracker i2cst_checker u_chk (
    .clk(clk), .rst_n(rst_n), .periph_en(periph_en), .arb_lost(arb_lost),
    .addr_done(addr_done), .rw_bit(addr_byte[0]),
    .stat(stat_word), .err(err_word),
    .stop_det(bus_evt.stop), .rstart_det(rstart)
);

// File: tb/tb_i2c_status_tracker.sv
module tb_i2c_status_tracker;
    localparam int CLK_PERIOD = 10;
    localparam int N_RANDOM   = 4000;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       scl_in, sda_in, periph_en, gc_en;
    logic       start_gen, addr_done, arb_lost, xfer_active;
    logic [7:0] addr_byte;
    logic       reg_addr, reg_wr;
    logic [7:0] reg_wdata;
    logic [7:0] reg_rdata;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    // bench model state
    bit m_msl, m_busy, m_tra, m_gc, m_arlo, m_berr;
    bit h_scl [4];
    bit h_sda [4];

    i2c_status_tracker dut (
        .clk(clk), .rst_n(rst_n), .scl_in(scl_in), .sda_in(sda_in),
        .periph_en(periph_en), .gc_en(gc_en), .start_gen(start_gen),
        .addr_done(addr_done), .addr_byte(addr_byte), .arb_lost(arb_lost),
        .xfer_active(xfer_active), .reg_addr(reg_addr), .reg_wr(reg_wr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic bit [7:0] exp_stat();
        return {3'b000, m_gc, 1'b0, m_tra, m_busy, m_msl};
    endfunction

    function automatic bit [7:0] exp_err();
        return {6'b000000, m_arlo, m_berr};
    endfunction

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] expv);
        checks++;
        if (act !== expv) begin
            errors++;
            $display("FAIL %s: actual=%02h expected=%02h at %0t", req, act, expv, $time);
        end
    endtask

    // compare both words with the model, field by field
    task automatic compare_all();
        bit [7:0] s, e;
        s = exp_stat();
        e = exp_err();
        reg_addr = 1'b0; #1;
        chk("R3 master role", {7'b0, reg_rdata[0]}, {7'b0, s[0]});
        chk("R2 busy",        {7'b0, reg_rdata[1]}, {7'b0, s[1]});
        chk("R4 direction",   {7'b0, reg_rdata[2]}, {7'b0, s[2]});
        chk("R5 general call",{7'b0, reg_rdata[4]}, {7'b0, s[4]});
        chk("R1 status reserved", reg_rdata & 8'hE8, 8'h00);
        reg_addr = 1'b1; #1;
        chk("R6 arbitration lost", {7'b0, reg_rdata[1]}, {7'b0, e[1]});
        chk("R7 bus error",        {7'b0, reg_rdata[0]}, {7'b0, e[0]});
        chk("R1 error reserved",   reg_rdata & 8'hFC, 8'h00);
    endtask

    // model the next flag values from the requirements
    task automatic model_next(input bit wr, input bit wa, input bit [7:0] wd);
        bit cs, cd, ps, pd, st, sp, rs;
        bit n_msl, n_busy, n_tra, n_gc, n_arlo, n_berr;
        cs = h_scl[2]; cd = h_sda[2]; ps = h_scl[3]; pd = h_sda[3];
        st = cs & ps & pd & !cd;
        sp = cs & ps & !pd & cd;
        rs = st & m_busy;
        n_busy = sp ? 1'b0 : ((!cs || !cd) ? 1'b1 : m_busy);
        n_msl  = (sp || arb_lost || !periph_en) ? 1'b0 : (start_gen ? 1'b1 : m_msl);
        n_tra  = (sp || rs || arb_lost || !periph_en) ? 1'b0 :
                 (addr_done ? addr_byte[0] : m_tra);
        n_gc   = (sp || rs || !periph_en) ? 1'b0 :
                 ((addr_done && gc_en && addr_byte == 8'h00) ? 1'b1 : m_gc);
        n_arlo = !periph_en ? 1'b0 : (arb_lost ? 1'b1 :
                 ((wr && wa && !wd[1]) ? 1'b0 : m_arlo));
        n_berr = !periph_en ? 1'b0 : (((st || sp) && xfer_active) ? 1'b1 :
                 ((wr && wa && !wd[0]) ? 1'b0 : m_berr));
        m_msl = n_msl; m_busy = n_busy; m_tra = n_tra;
        m_gc = n_gc; m_arlo = n_arlo; m_berr = n_berr;
    endtask

    // one cycle: check, apply inputs, update model, advance to next negedge
    task automatic cycle(input bit scl, input bit sda, input bit en, input bit gce,
                         input bit sg, input bit ad, input bit [7:0] ab, input bit al,
                         input bit xa, input bit wr, input bit wa, input bit [7:0] wd);
        compare_all();
        scl_in = scl; sda_in = sda; periph_en = en; gc_en = gce;
        start_gen = sg; addr_done = ad; addr_byte = ab; arb_lost = al;
        xfer_active = xa; reg_wr = wr; reg_addr = wa; reg_wdata = wd;
        for (int i = 3; i > 0; i--) begin
            h_scl[i] = h_scl[i-1];
            h_sda[i] = h_sda[i-1];
        end
        h_scl[0] = scl; h_sda[0] = sda;
        model_next(wr, wa, wd);
        @(posedge clk);
        @(negedge clk);
    endtask

    // idle cycle with given lines and enable
    task automatic idle(input bit scl, input bit sda, input bit en, input int n);
        for (int i = 0; i < n; i++)
            cycle(scl, sda, en, 1'b1, 0, 0, 8'h55, 0, 0, 0, 0, 8'hFF);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        bit scl_v, sda_v, en_v;
        void'($urandom(32'h1C2B));
        rst_n = 1'b0; scl_in = 1; sda_in = 1; periph_en = 0; gc_en = 0;
        start_gen = 0; addr_done = 0; addr_byte = 0; arb_lost = 0;
        xfer_active = 0; reg_addr = 0; reg_wr = 0; reg_wdata = 0;
        for (int i = 0; i < 4; i++) begin h_scl[i] = 1; h_sda[i] = 1; end
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state of both words
        reg_addr = 0; #1; chk("R1 reset status", reg_rdata, 8'h00);
        reg_addr = 1; #1; chk("R1 reset error", reg_rdata, 8'h00);

        // R10 latency: SDA low seen by busy only after the third edge
        cycle(1, 0, 1, 1, 0, 0, 8'h00, 0, 0, 0, 0, 8'hFF);
        cycle(1, 0, 1, 1, 0, 0, 8'h00, 0, 0, 0, 0, 8'hFF);
        reg_addr = 0; #1; chk("R10 busy before third edge", {7'b0, reg_rdata[1]}, 8'h00);
        cycle(1, 0, 1, 1, 0, 0, 8'h00, 0, 0, 0, 0, 8'hFF);
        reg_addr = 0; #1; chk("R10 busy at third edge", {7'b0, reg_rdata[1]}, 8'h01);

        // master start, general call address, then repeated start clears
        cycle(1, 0, 1, 1, 1, 0, 8'h00, 0, 0, 0, 0, 8'hFF);
        idle(0, 0, 1, 2);
        cycle(0, 0, 1, 1, 0, 1, 8'h00, 0, 0, 0, 0, 8'hFF);
        reg_addr = 0; #1; chk("R5 general call set", reg_rdata & 8'h17, 8'h13);
        idle(0, 1, 1, 3); idle(1, 1, 1, 3); idle(1, 0, 1, 4);
        reg_addr = 0; #1; chk("R4 R5 repeated start clears", reg_rdata & 8'h14, 8'h00);
        // transmit direction, then Stop clears everything but errors
        cycle(0, 0, 1, 1, 0, 1, 8'hA1, 0, 0, 0, 0, 8'hFF);
        idle(0, 0, 1, 1);
        reg_addr = 0; #1; chk("R4 direction transmit", reg_rdata & 8'h04, 8'h04);
        idle(1, 0, 1, 3); idle(1, 1, 1, 4);
        reg_addr = 0; #1; chk("R2 R3 stop clears", reg_rdata, 8'h00);

        // R2 busy tracks while disabled; R9 enable low
        idle(0, 1, 0, 4);
        reg_addr = 0; #1; chk("R2 busy while disabled", reg_rdata, 8'h02);
        idle(1, 1, 0, 1); idle(1, 0, 1, 2);

        // R7 misplaced start/stop during transfer
        cycle(1, 0, 1, 1, 0, 0, 8'h00, 0, 1, 0, 0, 8'hFF);
        idle(1, 0, 1, 1);
        cycle(1, 1, 1, 1, 0, 0, 8'h00, 0, 1, 0, 0, 8'hFF);
        cycle(1, 1, 1, 1, 0, 0, 8'h00, 0, 1, 0, 0, 8'hFF);
        cycle(1, 1, 1, 1, 0, 0, 8'h00, 0, 1, 0, 0, 8'hFF);
        reg_addr = 1; #1; chk("R7 bus error set", reg_rdata, 8'h01);
        // R6 then R8: write 0x02 keeps arlo, clears berr; hw set beats clear
        cycle(1, 1, 1, 1, 1, 0, 8'h00, 0, 0, 0, 0, 8'hFF);
        cycle(1, 1, 1, 1, 0, 0, 8'h00, 1, 0, 1, 1, 8'h00);
        reg_addr = 1; #1; chk("R8 hardware set wins", reg_rdata & 8'h02, 8'h02);
        reg_addr = 0; #1; chk("R6 master dropped", reg_rdata & 8'h01, 8'h00);
        cycle(1, 1, 1, 1, 0, 0, 8'h00, 0, 0, 1, 0, 8'h00);
        reg_addr = 0; #1; chk("R8 status write ignored", reg_rdata, 8'h00);
        cycle(1, 1, 1, 1, 0, 0, 8'h00, 0, 0, 1, 1, 8'h02);
        reg_addr = 1; #1; chk("R8 write zero clears", reg_rdata, 8'h02);
        idle(1, 1, 0, 1);
        reg_addr = 1; #1; chk("R9 disable clears errors", reg_rdata, 8'h00);

        // constrained random traffic checked against the model every cycle
        scl_v = 1; sda_v = 1; en_v = 1;
        for (int n = 0; n < N_RANDOM; n++) begin
            bit [7:0] ab;
            if ($urandom_range(3) == 0) scl_v = ~scl_v;
            else if ($urandom_range(3) == 0) sda_v = ~sda_v;
            if ($urandom_range(49) == 0) en_v = ~en_v;
            ab = ($urandom_range(3) == 0) ? 8'h00 : 8'($urandom);
            cycle(scl_v, sda_v, en_v, 1'($urandom), $urandom_range(15) == 0,
                  $urandom_range(15) == 0, ab, $urandom_range(23) == 0,
                  1'($urandom), $urandom_range(7) == 0, 1'($urandom), 8'($urandom));
        end
        compare_all();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule